// File: doc/BRIEF.md
# Packet-Ready Tracker for Multi-Queue Buffers

This block runs beside the storage of a multi-queue buffer whose words are 36 bits wide. When packet framing is in use, each word carries two marker bits at the top: the highest bit closes a packet and the one below it opens one. The block watches every write and every read. For each queue it keeps a count of the complete packets that are currently stored. It reports whether the queue chosen on the read side holds at least one whole packet. It also drives a per-queue status bus that carries packet availability while packet mode is active and the external almost-empty levels while it is not.

Packet mode is requested through a configuration load strobe, together with the current write and read port widths. The request is accepted only when both ports run at full width. Every load clears all counters. The read logic combines `pkt_ready` with its own output-valid indication to decide when a whole packet may be drained.

Top module: `pkt_ready_tracker`

## Requirements
- R1: After reset packet mode is off. On a cycle with `cfg_load` high, packet mode becomes on in the next cycle only if `cfg_pkt_mode` is 1 and both `cfg_wr_width` and `cfg_rd_width` equal 2'b10 (full width; 2'b00 and 2'b01 are narrower, 2'b11 is reserved). Any other request leaves it off, and `pkt_ready` stays 0.
- R2: While packet mode is on, a write (`wr_en`) whose bit 35 is 1 raises the packet count of queue `wr_q` by one, visible from the next cycle.
- R3: While packet mode is on, a read (`rd_en`) whose word `rd_data` has bit 35 set lowers the packet count of queue `rd_sel` by one, visible from the next cycle.
- R4: An end-marked write and an end-marked read to the same queue in one cycle leave its count unchanged. When they hit different queues, both counts change.
- R5: A word with both bit 34 and bit 35 set counts as a one-word packet. A word with only bit 34 set, or with neither bit set, changes no count.
- R6: `pkt_ready` is 1 exactly when packet mode is on and the count of queue `rd_sel` is nonzero.
- R7: Bit q of `q_status` is 1 when packet mode is on and queue q's count is nonzero. When packet mode is off, it equals `ae_in[q]`.
- R8: A cycle with `cfg_load` high clears every count, and this takes priority over writes and reads in that cycle.
- R9: A count saturates at MAX_PKTS (default 8). Further end-marked writes leave it there.
- R10: An end-marked read from a queue whose count is zero leaves the count at zero.
- R11: While packet mode is off, writes and reads change no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load the mode request and clear the counts |
| cfg_pkt_mode | input | 1 | Packet mode request |
| cfg_wr_width | input | 2 | Write port width code |
| cfg_rd_width | input | 2 | Read port width code |
| wr_en | input | 1 | Word written this cycle |
| wr_q | input | 2 | Queue receiving the write |
| wr_data | input | 36 | Word being written |
| rd_en | input | 1 | Word read this cycle |
| rd_sel | input | 2 | Queue selected on the read side |
| rd_data | input | 36 | Word read from the selected queue |
| ae_in | input | 4 | Almost-empty levels from the buffer, one bit per queue |
| pkt_mode_on | output | 1 | Packet mode active |
| pkt_ready | output | 1 | The selected read queue holds a complete packet |
| q_status | output | 4 | Per-queue packet availability, or the almost-empty levels |

## Verification
The assertions assume that `wr_q` and `rd_sel` always name an existing queue and that the inputs are free of X after reset. They take no position on whether the framing is well formed, because the counters define their own result for a stray end marker or for a count that reaches its limit. The stimulus uses only the four valid queue indices. It does send unbalanced end markers, underflow and saturation runs, and mid-stream configuration loads, because the requirements define the result of each of these.

// File: rtl/pkt_trk_pkg.sv
package pkt_trk_pkg;

   typedef enum logic [1:0] {
      PW_NARROW9  = 2'b00,
      PW_NARROW18 = 2'b01,
      PW_FULL36   = 2'b10,
      PW_RSVD     = 2'b11
   } port_width_e;

   function automatic logic widths_allow_pkt(input logic [1:0] wr_w, input logic [1:0] rd_w);
      return (port_width_e'(wr_w) == PW_FULL36) && (port_width_e'(rd_w) == PW_FULL36);
   endfunction

endpackage

// File: rtl/pkt_mode_gate.sv
module pkt_mode_gate
   import pkt_trk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_load,
   input  logic       cfg_pkt_mode,
   input  logic [1:0] cfg_wr_width,
   input  logic [1:0] cfg_rd_width,
   output logic       mode_on,
   output logic       clr_counts
);

   logic accept;

   assign accept     = cfg_pkt_mode && widths_allow_pkt(cfg_wr_width, cfg_rd_width);
   assign clr_counts = cfg_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_on <= 1'b0;
      else if (cfg_load) mode_on <= accept;
   end

   // R1: a load takes the mode only with both ports at full width
   a_r1_width_gate: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (mode_on == $past(cfg_pkt_mode && cfg_wr_width == 2'b10 && cfg_rd_width == 2'b10)));

   // R1: without a load the mode holds
   a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(mode_on));

endmodule

// File: rtl/pkt_marker_decode.sv
module pkt_marker_decode #(
   parameter int NUM_Q  = 4,
   parameter int DATA_W = 36,
   localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
   localparam int EOP_B = DATA_W - 1
) (
   input  logic              mode_on,
   input  logic              wr_en,
   input  logic [QW-1:0]     wr_q,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [QW-1:0]     rd_sel,
   input  logic [DATA_W-1:0] rd_data,
   output logic [NUM_Q-1:0]  inc,
   output logic [NUM_Q-1:0]  dec
);

   logic wr_close, rd_close;

   // only the end marker moves a count; the start marker is informational
   assign wr_close = mode_on && wr_en && wr_data[EOP_B];
   assign rd_close = mode_on && rd_en && rd_data[EOP_B];

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      assign inc[q] = wr_close && (wr_q == QW'(q));
      assign dec[q] = rd_close && (rd_sel == QW'(q));
   end

endmodule

// File: rtl/pkt_q_counter.sv
module pkt_q_counter #(
   parameter int MAX_PKTS = 8,
   localparam int CNT_W   = $clog2(MAX_PKTS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec,
   output logic nonzero
);

   logic [CNT_W-1:0] cnt;
   logic             at_max, at_zero;

   assign at_max  = (cnt == CNT_W'(MAX_PKTS));
   assign at_zero = (cnt == '0);
   assign nonzero = !at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (clr)                        cnt <= '0;
      else if (inc && !dec && !at_max)     cnt <= cnt + CNT_W'(1);
      else if (dec && !inc && !at_zero)    cnt <= cnt - CNT_W'(1);
   end

   // R2: a lone close on write adds one below the limit
   a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && !clr && cnt < CNT_W'(MAX_PKTS)) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R3: a lone close on read removes one above zero
   a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !clr && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

   // R4: simultaneous close on both sides is neutral
   a_r4_balanced: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec && !clr) |=> $stable(cnt));

   // R8: a load empties the counter
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   // R9: never beyond the limit
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MAX_PKTS));

   // R10: a read close at zero stays at zero
   a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !clr && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker #(
   parameter int NUM_Q    = 4,
   parameter int DATA_W   = 36,
   parameter int MAX_PKTS = 8,
   localparam int QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic              cfg_pkt_mode,
   input  logic [1:0]        cfg_wr_width,
   input  logic [1:0]        cfg_rd_width,
   input  logic              wr_en,
   input  logic [QW-1:0]     wr_q,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [QW-1:0]     rd_sel,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [NUM_Q-1:0]  ae_in,
   output logic              pkt_mode_on,
   output logic              pkt_ready,
   output logic [NUM_Q-1:0]  q_status
);

   if (NUM_Q < 1) begin : g_bad_nq
      $error("pkt_ready_tracker: NUM_Q must be at least 1");
   end
   if (DATA_W < 3) begin : g_bad_dw
      $error("pkt_ready_tracker: DATA_W must hold two markers and data");
   end
   if (MAX_PKTS < 1) begin : g_bad_max
      $error("pkt_ready_tracker: MAX_PKTS must be at least 1");
   end

   logic             clr_counts;
   logic [NUM_Q-1:0] inc, dec, has_pkt;

   pkt_mode_gate u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_load     (cfg_load),
      .cfg_pkt_mode (cfg_pkt_mode),
      .cfg_wr_width (cfg_wr_width),
      .cfg_rd_width (cfg_rd_width),
      .mode_on      (pkt_mode_on),
      .clr_counts   (clr_counts)
   );

   pkt_marker_decode #(.NUM_Q(NUM_Q), .DATA_W(DATA_W)) u_dec (
      .mode_on (pkt_mode_on),
      .wr_en   (wr_en),
      .wr_q    (wr_q),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .inc     (inc),
      .dec     (dec)
   );

   for (genvar q = 0; q < NUM_Q; q++) begin : g_cnt
      pkt_q_counter #(.MAX_PKTS(MAX_PKTS)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr_counts),
         .inc     (inc[q]),
         .dec     (dec[q]),
         .nonzero (has_pkt[q])
      );
      assign q_status[q] = pkt_mode_on ? has_pkt[q] : ae_in[q];
   end

   if (NUM_Q == (1 << QW)) begin : g_full_sel
      assign pkt_ready = pkt_mode_on && has_pkt[rd_sel];
   end else begin : g_part_sel
      assign pkt_ready = pkt_mode_on && (32'(rd_sel) < NUM_Q) && has_pkt[rd_sel];
   end

   // R6: readiness only exists in packet mode
   a_r6_ready_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_ready |-> pkt_mode_on);

   // R7: outside packet mode the status bus carries the levels
   a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_mode_on |-> (q_status == ae_in));

   // R11: no counting while the mode is off
   a_r11_idle_counts: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_mode_on |-> (inc == '0 && dec == '0));

endmodule

// File: tb/sim_pkt_ready_tracker.sv
`timescale 1ns/1ps
module sim_pkt_ready_tracker;

   localparam int NQ   = 4;
   localparam int DW   = 36;
   localparam int MAXP = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          cfg_load, cfg_pkt_mode;
   logic [1:0]    cfg_wr_width, cfg_rd_width;
   logic          wr_en, rd_en;
   logic [1:0]    wr_q, rd_sel;
   logic [DW-1:0] wr_data, rd_data;
   logic [NQ-1:0] ae_in;
   logic          pkt_mode_on, pkt_ready;
   logic [NQ-1:0] q_status;

   pkt_ready_tracker #(.NUM_Q(NQ), .DATA_W(DW), .MAX_PKTS(MAXP)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_pkt_mode(cfg_pkt_mode),
      .cfg_wr_width(cfg_wr_width), .cfg_rd_width(cfg_rd_width),
      .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
      .ae_in(ae_in), .pkt_mode_on(pkt_mode_on), .pkt_ready(pkt_ready), .q_status(q_status)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int exp_cnt[NQ];
   bit exp_mode;
   bit done = 0;

   function automatic bit exp_ready();
      return exp_mode && exp_cnt[rd_sel] > 0;
   endfunction

   function automatic logic [NQ-1:0] exp_status();
      logic [NQ-1:0] s;
      for (int q = 0; q < NQ; q++) s[q] = exp_mode ? (exp_cnt[q] > 0) : ae_in[q];
      return s;
   endfunction

   task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(string tag);
      cmp({tag, " mode"},   64'(pkt_mode_on), 64'(exp_mode));
      cmp({tag, " ready"},  64'(pkt_ready),   64'(exp_ready()));
      cmp({tag, " status"}, 64'(q_status),    64'(exp_status()));
   endtask

   task automatic model_edge();
      if (cfg_load) begin
         exp_mode = cfg_pkt_mode && cfg_wr_width == 2'b10 && cfg_rd_width == 2'b10;
         for (int q = 0; q < NQ; q++) exp_cnt[q] = 0;
      end else if (exp_mode) begin
         for (int q = 0; q < NQ; q++) begin
            bit up, dn;
            up = wr_en && wr_data[35] && wr_q == 2'(q);
            dn = rd_en && rd_data[35] && rd_sel == 2'(q);
            if (up && !dn && exp_cnt[q] < MAXP) exp_cnt[q]++;
            else if (dn && !up && exp_cnt[q] > 0) exp_cnt[q]--;
         end
      end
   endtask

   task automatic idle();
      cfg_load = 0; wr_en = 0; rd_en = 0;
      wr_data = '0; rd_data = '0;
   endtask

   // one clock: inputs set at the falling edge before, result checked at the next falling edge
   task automatic step(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all(tag);
      idle();
   endtask

   task automatic load(bit req, logic [1:0] ww, logic [1:0] rw, string tag);
      cfg_load = 1; cfg_pkt_mode = req; cfg_wr_width = ww; cfg_rd_width = rw;
      step(tag);
   endtask

   task automatic put(logic [1:0] q, bit sop, bit eop);
      wr_en = 1; wr_q = q;
      wr_data = {eop, sop, 34'(q) ^ 34'h2_A5A5_A5A5};
   endtask

   task automatic take(logic [1:0] q, bit eop);
      rd_en = 1; rd_sel = q;
      rd_data = {eop, 1'b0, 34'h1_2345_6789};
   endtask

   initial begin
      #(5.0 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 0; cfg_pkt_mode = 0; cfg_wr_width = 2'b10; cfg_rd_width = 2'b10;
      wr_q = 0; rd_sel = 0; ae_in = 4'b1010;
      idle();
      exp_mode = 0;
      for (int q = 0; q < NQ; q++) exp_cnt[q] = 0;
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      check_all("R7 reset passthrough");
      rst_n = 1;
      @(negedge clk);

      // R1 refused requests: narrow write, narrow read, reserved code
      load(1, 2'b01, 2'b10, "R1 narrow wr");
      put(0, 1, 1); step("R11 off write");
      load(1, 2'b10, 2'b00, "R1 narrow rd");
      load(1, 2'b11, 2'b10, "R1 reserved");
      load(0, 2'b10, 2'b10, "R1 no request");
      ae_in = 4'b0101; step("R7 ae follow");

      // R1 accepted
      load(1, 2'b10, 2'b10, "R1 accept");
      rd_sel = 0;
      // R5: start-only and body words do not count
      put(0, 1, 0); step("R5 sop only");
      put(0, 0, 0); step("R5 body");
      put(0, 0, 1); step("R2 eop write");
      put(1, 1, 1); step("R5 one-word packet");
      rd_sel = 1; step("R6 sel q1");
      // R4: same queue, both sides close
      put(1, 0, 1); take(1, 1); step("R4 same queue");
      // R4: different queues
      put(2, 1, 1); take(1, 1); step("R4 diff queue");
      rd_sel = 0; take(0, 1); step("R3 eop read");
      // R10: underflow
      take(0, 1); step("R10 floor");
      put(0, 1, 1); step("R10 after floor");
      take(0, 1); step("R10 drain");
      // R9: saturation on queue 3
      rd_sel = 3;
      for (int i = 0; i < MAXP + 3; i++) begin put(3, 1, 1); step("R9 fill"); end
      for (int i = 0; i < MAXP; i++) begin take(3, 1); step("R9 drain"); end
      // R8: load clears, and wins over a same-cycle write
      put(2, 1, 1); step("R2 q2");
      put(2, 1, 1); cfg_load = 1; cfg_pkt_mode = 1; step("R8 clear");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         ae_in = 4'($urandom);
         rd_sel = 2'($urandom);
         if ($urandom_range(0, 2) != 0) put(2'($urandom), 1'($urandom), 1'($urandom));
         if ($urandom_range(0, 2) == 0) take(rd_sel, 1'($urandom));
         if ($urandom_range(0, 99) == 0) begin
            cfg_load = 1; cfg_pkt_mode = ($urandom_range(0, 3) != 0);
            cfg_wr_width = ($urandom_range(0, 3) != 0) ? 2'b10 : 2'($urandom);
            cfg_rd_width = ($urandom_range(0, 3) != 0) ? 2'b10 : 2'($urandom);
         end
         step("R2/R3/R6/R7 random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule